// File: doc/BRIEF.md
# Single-to-Half Precision Rounding Converter

This block narrows a 32-bit single-precision floating-point operand to a 16-bit half-precision result. The rounding is correct in all four directed modes, and each case raises the matching exception flags. Each request carries its own mode bits, so neighbouring operations may use different settings. The per-request mode bits are:

- a 2-bit rounding mode;
- an alternative-format select, for a half format that has no infinity or NaN encodings;
- a default-NaN select;
- a flush-to-zero select for subnormal inputs.

The unit has two register stages. The first stage decodes the operand class and aligns the significand to the half-precision grid, which gives kept bits, a guard bit and a sticky bit. The second stage rounds, handles any carry, resolves overflow for the chosen output format, and registers the result and five flags: invalid, overflow, underflow, inexact and input-denormal. A new operand may enter every cycle. The result of an operand accepted in cycle N is valid in cycle N+2.

Top module: `sp2hp_narrow`

## Requirements
- R1: A valid operand appears with `out_valid` high exactly two clock cycles after it was presented with `in_valid`. Cycles without `in_valid` produce no `out_valid`, and synchronous reset clears `out_valid`.
- R2: Finite results are rounded by `in_rmode`. Code 0 is nearest-even: round up when the discarded part exceeds half an ulp, or equals half and the kept LSB is 1. Code 1 is toward +infinity: round up when inexact and positive. Code 2 is toward −infinity: round up when inexact and negative. Code 3 is toward zero: never round up. Inexact is raised whenever discarded bits are nonzero.
- R3: In the IEEE format (`in_alt_fmt`=0), a rounded biased exponent of 31 or more gives overflow, and both overflow and inexact are raised. The result is ±infinity (0x7C00 with the sign) in mode 0, and in mode 1 when positive or mode 2 when negative. Otherwise the result is the largest finite value (0x7BFF with the sign).
- R4: When the value is below the smallest normal half before rounding, the result is subnormal. Underflow is raised only if the result is also inexact. A round-up that fills the subnormal field produces the smallest normal (biased exponent 1).
- R5: A round-up that overflows an all-ones 10-bit fraction gives a zero fraction and increments the exponent by one.
- R6: In the IEEE format, an infinite input gives ±infinity with no flags, and a zero input in either format gives a zero of the same sign with no flags.
- R7: In the IEEE format, a NaN input whose fraction bit 22 is 0 (signalling) raises invalid, and a quiet NaN raises nothing. With `in_dflt_nan`=1 the result is 0x7E00. Otherwise the result keeps the sign, has an all-ones exponent, has fraction bit 9 set, and takes input fraction bits 21..13 into result bits 8..0.
- R8: In the alternative format (`in_alt_fmt`=1), exponent 31 encodes an ordinary normal value. An infinite input, or a rounded biased exponent of 32 or more, gives 0x7FFF with the sign, raises invalid and suppresses inexact.
- R9: In the alternative format, any NaN input gives a zero of the same sign and raises invalid.
- R10: A subnormal single input (exponent field 0, nonzero fraction) with `in_flush`=1 gives a zero of the same sign with only input-denormal raised. With `in_flush`=0 it rounds as a tiny value: ±0 or the smallest subnormal 0x0001, depending on mode and sign, with underflow and inexact raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand and mode bits are presented this cycle |
| in_single | input | 32 | Single-precision operand |
| in_rmode | input | 2 | Rounding mode: 0 nearest-even, 1 toward +inf, 2 toward −inf, 3 toward zero |
| in_alt_fmt | input | 1 | Select the alternative half format without infinity/NaN |
| in_dflt_nan | input | 1 | Return the default quiet NaN for NaN inputs (IEEE format) |
| in_flush | input | 1 | Flush subnormal inputs to signed zero |
| out_valid | output | 1 | Result and flags are valid this cycle |
| out_half | output | 16 | Half-precision result |
| out_invalid | output | 1 | Invalid-operation flag |
| out_overflow | output | 1 | Overflow flag |
| out_underflow | output | 1 | Underflow flag |
| out_inexact | output | 1 | Inexact flag |
| out_in_denorm | output | 1 | Input-denormal (flushed) flag |

## Verification
The operand exponent is swept over every value from 101 to 145, together with the extremes 0, 1, 254 and 255. This range covers the subnormal boundary, the subnormal-to-normal carry and the overflow threshold in both output formats. Each exponent is combined with fractions placed just below, exactly at and just above the halfway point, with LSB parities that separate round-to-even from round-away. All-ones fractions exercise the mantissa carry, and pseudo-random fractions fill in the rest. Every combination is tried under all four modes, both signs and both formats. The NaN fractions, with the quiet bit set and clear, and the flush and default-NaN settings vary across the sweep, so NaN propagation, default NaN, flushing and tiny unflushed inputs are each separated.

// File: rtl/sp2hp_pkg.sv
package sp2hp_pkg;
  localparam int SP_EW     = 8;
  localparam int SP_FW     = 23;
  localparam int HP_EW     = 5;
  localparam int HP_FW     = 10;
  localparam int SP_W      = 1 + SP_EW + SP_FW;
  localparam int HP_W      = 1 + HP_EW + HP_FW;
  localparam int SP_BIAS   = (1 << (SP_EW - 1)) - 1;
  localparam int HP_BIAS   = (1 << (HP_EW - 1)) - 1;
  localparam int SIG_W     = SP_FW + 1;
  localparam int KEEP_W    = HP_FW + 1;
  localparam int XEXP_W    = SP_EW + 2;
  localparam int SHIFT_CAP = SIG_W;
  localparam int ALN_W     = 2 * SIG_W;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_UP   = 2'd1,
    RM_DOWN = 2'd2,
    RM_ZERO = 2'd3
  } rmode_e;

  typedef enum logic [2:0] {
    CL_NUM   = 3'd0,
    CL_ZERO  = 3'd1,
    CL_INF   = 3'd2,
    CL_NAN   = 3'd3,
    CL_FLUSH = 3'd4
  } opcls_e;

  typedef struct packed {
    logic                     sign;
    opcls_e                   cls;
    logic [KEEP_W-1:0]        kept;
    logic                     guard;
    logic                     sticky;
    logic signed [XEXP_W-1:0] exp_pre;
    logic                     nan_quiet;
    logic [HP_FW-2:0]         nan_pay;
    rmode_e                   rmode;
    logic                     alt_fmt;
    logic                     dflt_nan;
  } s1_t;

  typedef struct packed {
    logic invalid;
    logic overflow;
    logic underflow;
    logic inexact;
    logic in_denorm;
  } flags_t;
endpackage

// File: rtl/sp2hp_unpack.sv
module sp2hp_unpack
  import sp2hp_pkg::*;
(
  input  logic [SP_W-1:0] op,
  input  logic [1:0]      rmode,
  input  logic            alt_fmt,
  input  logic            dflt_nan,
  input  logic            flush,
  output s1_t             dec
);
  localparam int SH_W = $clog2(SHIFT_CAP + 1);
  localparam logic signed [XEXP_W-1:0] REBIAS = XEXP_W'(SP_BIAS - HP_BIAS);
  localparam logic signed [XEXP_W-1:0] ONE_X  = XEXP_W'(1);
  localparam logic signed [XEXP_W-1:0] ZERO_X = XEXP_W'(0);
  localparam logic signed [XEXP_W-1:0] CAP_X  = XEXP_W'(SHIFT_CAP);

  logic                     sign;
  logic [SP_EW-1:0]         ex;
  logic [SP_FW-1:0]         fr;
  logic                     ex_max, ex_zero, fr_zero;
  logic [SP_EW-1:0]         ex_eff;
  logic signed [XEXP_W-1:0] he, deficit;
  logic [SH_W-1:0]          sh;
  logic [SIG_W-1:0]         sig;
  logic [ALN_W-1:0]         aln;

  always_comb begin
    sign    = op[SP_W-1];
    ex      = op[SP_W-2 -: SP_EW];
    fr      = op[SP_FW-1:0];
    ex_max  = &ex;
    ex_zero = ~|ex;
    fr_zero = ~|fr;

    // subnormal singles share the exponent of the smallest normal
    ex_eff  = ex_zero ? SP_EW'(1) : ex;
    he      = $signed({2'b00, ex_eff}) - REBIAS;
    deficit = ONE_X - he;

    if (he > ZERO_X)         sh = '0;
    else if (deficit >= CAP_X) sh = SH_W'(SHIFT_CAP);
    else                     sh = SH_W'(deficit);

    sig = {~ex_zero, fr};
    aln = {sig, {SIG_W{1'b0}}} >> sh;

    dec.sign      = sign;
    dec.kept      = aln[ALN_W-1 -: KEEP_W];
    dec.guard     = aln[ALN_W-1-KEEP_W];
    dec.sticky    = |aln[ALN_W-2-KEEP_W:0];
    dec.exp_pre   = (he > ZERO_X) ? he : ZERO_X;
    dec.nan_quiet = fr[SP_FW-1];
    dec.nan_pay   = fr[SP_FW-2 -: (HP_FW-1)];
    dec.rmode     = rmode_e'(rmode);
    dec.alt_fmt   = alt_fmt;
    dec.dflt_nan  = dflt_nan;

    if (ex_max && fr_zero)       dec.cls = CL_INF;
    else if (ex_max)             dec.cls = CL_NAN;
    else if (ex_zero && fr_zero) dec.cls = CL_ZERO;
    else if (ex_zero && flush)   dec.cls = CL_FLUSH;
    else                         dec.cls = CL_NUM;
  end
endmodule

// File: rtl/sp2hp_round.sv
module sp2hp_round
  import sp2hp_pkg::*;
(
  input  s1_t             d,
  output logic [HP_W-1:0] res,
  output flags_t          flg
);
  localparam logic [HP_EW-1:0] EXP_ONES  = '1;
  localparam logic [HP_EW-1:0] EXP_TOP   = EXP_ONES - HP_EW'(1);
  localparam logic [HP_FW-1:0] FRAC_ONES = '1;
  localparam logic signed [XEXP_W-1:0] IEEE_LIM = XEXP_W'((1 << HP_EW) - 1);
  localparam logic signed [XEXP_W-1:0] ALT_LIM  = XEXP_W'(1 << HP_EW);
  localparam logic signed [XEXP_W-1:0] ZERO_X   = XEXP_W'(0);

  logic                     inexact_raw, up, to_inf, tiny, carry;
  logic [KEEP_W:0]          mant;
  logic signed [XEXP_W-1:0] ex_post;
  logic [HP_FW-1:0]         frac;
  logic [HP_W-1:0]          packed_res, inf_res, maxfin_res, altmax_res, zero_res;

  always_comb begin
    inexact_raw = d.guard | d.sticky;
    up     = 1'b0;
    to_inf = 1'b0;
    unique case (d.rmode)
      RM_NEAR: begin up = d.guard & (d.sticky | d.kept[0]); to_inf = 1'b1;    end
      RM_UP:   begin up = inexact_raw & ~d.sign;           to_inf = ~d.sign; end
      RM_DOWN: begin up = inexact_raw & d.sign;            to_inf = d.sign;  end
      default: begin up = 1'b0;                            to_inf = 1'b0;    end
    endcase

    tiny    = (d.exp_pre == ZERO_X);
    mant    = {1'b0, d.kept} + {{KEEP_W{1'b0}}, up};
    // subnormal carry reaches the hidden position, normal carry one above
    carry   = tiny ? mant[KEEP_W-1] : mant[KEEP_W];
    ex_post = d.exp_pre + $signed({{(XEXP_W-1){1'b0}}, carry});
    frac    = mant[KEEP_W] ? mant[KEEP_W-1:1] : mant[HP_FW-1:0];

    packed_res = {d.sign, ex_post[HP_EW-1:0], frac};
    inf_res    = {d.sign, EXP_ONES, {HP_FW{1'b0}}};
    maxfin_res = {d.sign, EXP_TOP, FRAC_ONES};
    altmax_res = {d.sign, EXP_ONES, FRAC_ONES};
    zero_res   = {d.sign, {(HP_W-1){1'b0}}};

    res = zero_res;
    flg = '0;
    unique case (d.cls)
      CL_ZERO: res = zero_res;
      CL_FLUSH: begin
        res           = zero_res;
        flg.in_denorm = 1'b1;
      end
      CL_INF: begin
        if (d.alt_fmt) begin
          res         = altmax_res;
          flg.invalid = 1'b1;
        end else begin
          res = inf_res;
        end
      end
      CL_NAN: begin
        if (d.alt_fmt) begin
          res         = zero_res;
          flg.invalid = 1'b1;
        end else begin
          flg.invalid = ~d.nan_quiet;
          if (d.dflt_nan) res = {1'b0, EXP_ONES, 1'b1, {(HP_FW-1){1'b0}}};
          else            res = {d.sign, EXP_ONES, 1'b1, d.nan_pay};
        end
      end
      default: begin
        if (!d.alt_fmt && ex_post >= IEEE_LIM) begin
          res          = to_inf ? inf_res : maxfin_res;
          flg.overflow = 1'b1;
          flg.inexact  = 1'b1;
        end else if (d.alt_fmt && ex_post >= ALT_LIM) begin
          res         = altmax_res;
          flg.invalid = 1'b1;
        end else begin
          res           = packed_res;
          flg.inexact   = inexact_raw;
          flg.underflow = tiny & inexact_raw;
        end
      end
    endcase
  end
endmodule

// File: rtl/sp2hp_narrow.sv
module sp2hp_narrow
  import sp2hp_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [SP_W-1:0] in_single,
  input  logic [1:0]      in_rmode,
  input  logic            in_alt_fmt,
  input  logic            in_dflt_nan,
  input  logic            in_flush,
  output logic            out_valid,
  output logic [HP_W-1:0] out_half,
  output logic            out_invalid,
  output logic            out_overflow,
  output logic            out_underflow,
  output logic            out_inexact,
  output logic            out_in_denorm
);
  s1_t             dec, s1_q;
  logic            s1_vld;
  logic [HP_W-1:0] rnd_res;
  flags_t          rnd_flg;

  sp2hp_unpack u_unpack (
    .op       (in_single),
    .rmode    (in_rmode),
    .alt_fmt  (in_alt_fmt),
    .dflt_nan (in_dflt_nan),
    .flush    (in_flush),
    .dec      (dec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0;
      s1_q   <= '0;
    end else begin
      s1_vld <= in_valid;
      if (in_valid) s1_q <= dec;
    end
  end

  sp2hp_round u_round (
    .d   (s1_q),
    .res (rnd_res),
    .flg (rnd_flg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_half      <= '0;
      out_invalid   <= 1'b0;
      out_overflow  <= 1'b0;
      out_underflow <= 1'b0;
      out_inexact   <= 1'b0;
      out_in_denorm <= 1'b0;
    end else begin
      out_valid <= s1_vld;
      if (s1_vld) begin
        out_half      <= rnd_res;
        out_invalid   <= rnd_flg.invalid;
        out_overflow  <= rnd_flg.overflow;
        out_underflow <= rnd_flg.underflow;
        out_inexact   <= rnd_flg.inexact;
        out_in_denorm <= rnd_flg.in_denorm;
      end
    end
  end
endmodule

// File: rtl/sp2hp_narrow_chk.sv
module sp2hp_narrow_chk
  import sp2hp_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            in_alt_fmt,
  input logic            out_valid,
  input logic [HP_W-1:0] out_half,
  input logic            out_invalid,
  input logic            out_overflow,
  input logic            out_underflow,
  input logic            out_inexact,
  input logic            out_in_denorm
);
  logic alt_d1, alt_d2;

  always_ff @(posedge clk) begin
    if (rst) begin
      alt_d1 <= 1'b0;
      alt_d2 <= 1'b0;
    end else begin
      alt_d1 <= in_alt_fmt;
      alt_d2 <= alt_d1;
    end
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 out_valid);

  p_bubble_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ##1 !out_valid);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_overflow) |-> (out_inexact && !out_underflow &&
      (out_half[HP_W-2:0] == 15'h7C00 || out_half[HP_W-2:0] == 15'h7BFF)));

  p_underflow_inexact_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_underflow) |-> out_inexact);

  p_snan_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !alt_d2 && out_invalid) |->
      (out_half[HP_W-2 -: HP_EW] == '1 && out_half[HP_FW-1]));

  p_alt_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && alt_d2) |-> !out_overflow);

  p_flush_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_in_denorm) |->
      (out_half[HP_W-2:0] == '0 &&
       $countones({out_invalid, out_overflow, out_underflow, out_inexact}) == 0));
endmodule

bind sp2hp_narrow sp2hp_narrow_chk chk_i (.*);

// File: tb/sp2hp_narrow_tb.sv
`timescale 1ns/1ps
module sp2hp_narrow_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] in_single;
  logic [1:0]  in_rmode;
  logic        in_alt_fmt, in_dflt_nan, in_flush;
  logic        out_valid;
  logic [15:0] out_half;
  logic        out_invalid, out_overflow, out_underflow, out_inexact, out_in_denorm;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;

  logic [20:0] exq[$];
  int          cq[$];
  string       tq[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sp2hp_narrow dut_i (.*);

  // Expected {half, invalid, overflow, underflow, inexact, in_denorm}
  function automatic logic [20:0] ref_conv(input logic [31:0] a, input logic [1:0] rm,
                                           input logic alt, input logic dn, input logic fz,
                                           output string tag);
    logic s; int e; logic [22:0] f;
    longint sig, n, rem, half;
    int ee, p, lg, ulp, k, hx;
    logic up, toinf, tiny, inx, inv, ovf, unf, den;
    logic [15:0] r;
    s = a[31]; e = int'(a[30:23]); f = a[22:0];
    r = '0; inv = 0; ovf = 0; unf = 0; inx = 0; den = 0; tag = "R2";
    if (e == 255 && f == 0) begin
      tag = alt ? "R8" : "R6"; inv = alt;
      r = alt ? {s, 15'h7FFF} : {s, 15'h7C00};
    end else if (e == 255) begin
      if (alt) begin tag = "R9"; r = {s, 15'h0}; inv = 1; end
      else begin
        tag = "R7"; inv = !f[22];
        r = dn ? 16'h7E00 : {s, 5'h1F, 1'b1, f[21:13]};
      end
    end else if (e == 0 && f == 0) begin
      tag = "R6"; r = {s, 15'h0};
    end else if (e == 0 && fz) begin
      tag = "R10"; r = {s, 15'h0}; den = 1;
    end else begin
      sig = (e == 0) ? longint'(f) : (longint'(f) | (64'sd1 <<< 23));
      ee  = (e == 0) ? -149 : e - 150;
      p = 0;
      for (int i = 0; i < 24; i++) if (sig[i]) p = i;
      lg   = ee + p;
      tiny = (lg < -14);
      ulp  = (tiny ? -14 : lg) - 10;
      k    = ulp - ee;
      if (k > 40) k = 40;
      n    = sig >>> k;
      rem  = sig - (n <<< k);
      half = 64'sd1 <<< (k - 1);
      inx  = (rem != 0);
      case (rm)
        2'd0: begin up = (rem > half) || (rem == half && n[0]); toinf = 1; end
        2'd1: begin up = inx && !s; toinf = !s; end
        2'd2: begin up = inx && s;  toinf = s;  end
        default: begin up = 0; toinf = 0; end
      endcase
      n = n + longint'(up);
      if (n == 2048) begin n = 1024; ulp = ulp + 1; tag = "R5"; end
      hx = (n >= 1024) ? ulp + 25 : 0;
      if (tiny) tag = (e == 0) ? "R10" : "R4";
      unf = tiny && inx;
      if (!alt && hx >= 31) begin
        tag = "R3"; ovf = 1; inx = 1; unf = 0;
        r = toinf ? {s, 15'h7C00} : {s, 15'h7BFF};
      end else if (alt && hx >= 32) begin
        tag = "R8"; inv = 1; inx = 0; r = {s, 15'h7FFF};
      end else begin
        if (alt && hx == 31) tag = "R8";
        r = {s, 5'(hx), 10'(n)};
      end
    end
    return {r, inv, ovf, unf, inx, den};
  endfunction

  // Output monitor, sampled on the falling edge
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      total++;
      if (exq.size() == 0) begin
        bad++;
        $display("FAIL R1: out_valid with no pending operand act=1 exp=0");
      end else begin
        logic [20:0] e;
        int c;
        string t;
        e = exq.pop_front(); c = cq.pop_front(); t = tq.pop_front();
        if (cyc - c != 2) begin
          bad++;
          $display("FAIL R1: latency act=%0d exp=2", cyc - c);
        end
        total++;
        if ({out_half, out_invalid, out_overflow, out_underflow, out_inexact, out_in_denorm} !== e) begin
          bad++;
          $display("FAIL %s: act=%h/%b%b%b%b%b exp=%h/%b", t, out_half, out_invalid,
                   out_overflow, out_underflow, out_inexact, out_in_denorm, e[20:5], e[4:0]);
        end
      end
    end
  end

  task automatic issue(input logic [31:0] a, input logic [1:0] rm,
                       input logic alt, input logic dn, input logic fz);
    string t;
    logic [20:0] e;
    @(negedge clk);
    e = ref_conv(a, rm, alt, dn, fz, t);
    in_valid = 1; in_single = a; in_rmode = rm;
    in_alt_fmt = alt; in_dflt_nan = dn; in_flush = fz;
    exq.push_back(e); cq.push_back(cyc); tq.push_back(t);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0;
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1: watchdog expired act=hung exp=complete");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [22:0] fr[24];
    int ex[$];
    int cnt;
    logic [31:0] lcg;
    fr[0] = 23'h000000; fr[1] = 23'h000001; fr[2] = 23'h001000; fr[3] = 23'h003000;
    fr[4] = 23'h000FFF; fr[5] = 23'h001001; fr[6] = 23'h7FFFFF; fr[7] = 23'h7FF000;
    fr[8] = 23'h7FEFFF; fr[9] = 23'h7FE000; fr[10] = 23'h400000; fr[11] = 23'h200000;
    fr[12] = 23'h000800; fr[13] = 23'h2AAAAA; fr[14] = 23'h555555; fr[15] = 23'h7FF001;
    lcg = 32'h1234_5678;
    for (int i = 16; i < 24; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      fr[i] = lcg[30:8];
    end
    ex = '{0, 1, 2, 3, 90, 200, 253, 254, 255};
    for (int e = 101; e <= 145; e++) ex.push_back(e);

    in_valid = 0; in_single = '0; in_rmode = '0;
    in_alt_fmt = 0; in_dflt_nan = 0; in_flush = 0;
    rst = 1;
    repeat (3) @(negedge clk);
    total++;
    if (out_valid !== 1'b0) begin
      bad++;
      $display("FAIL R1: out_valid in reset act=%b exp=0", out_valid);
    end
    rst = 0;

    cnt = 0;
    foreach (ex[xi]) begin
      for (int fi = 0; fi < 24; fi++) begin
        for (int m = 0; m < 4; m++) begin
          for (int sg = 0; sg < 2; sg++) begin
            for (int al = 0; al < 2; al++) begin
              issue({sg[0], ex[xi][7:0], fr[fi]}, m[1:0], al[0], cnt[5], cnt[4]);
              cnt++;
              if (cnt % 7 == 0) idle();
            end
          end
        end
      end
    end
    idle();
    repeat (4) @(negedge clk);
    total++;
    if (exq.size() != 0) begin
      bad++;
      $display("FAIL R1: results missing act=%0d exp=0", exq.size());
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule